// File: doc/BRIEF.md
# PCI Target Claim Decoder

This block sits at the front of a PCI-to-ISA bridge and settles two questions for each PCI transaction: whether the bridge claims it, and in which clock DEVSEL# goes low. It compares the address with a small set of I/O windows owned by the bridge. A hit there is a fast positive claim one clock after the address phase. When nothing positive matches, the bridge acts as the subtractive agent. It waits a number of clocks that software can set, and takes the cycle only if no other target has answered and the subtractive-inhibit input is low.

A boot test mode is entered with `rom_test_n` low while `boot_done` is low. In this mode the 1 MB boot ROM window at the top of the 32-bit space is positively decoded, so a ROM on an ISA card can be found. The inhibit input does not act on that window. Once `boot_done` is set, the ROM window is claimed only by subtraction, like any other address. The block also produces even parity over AD and C/BE#, and flags the clock in which that parity must be driven after a claimed read data phase.

Cycle numbering used below: cycle 0 is the address phase, the clock in which FRAME# is first sampled low from idle. Cycle n follows n clock edges later.

Top module: `pci_target_claim`

## Requirements
- R1: While reset is applied and after it is released, `devsel_out_n` is high and `par_en` is low until a transaction is claimed.
- R2: An I/O command (C/BE# 0010 or 0011) whose address falls in one of the bridge's 16-byte I/O windows (defaults 0x300 and 0x220, all 32 bits compared) drives `devsel_out_n` low from cycle 1. The same address with a memory command is not claimed positively.
- R3: A claimed transaction holds `devsel_out_n` low until the clock in which FRAME# is high and IRDY# and TRDY# are both low. It releases it in the next cycle.
- R4: With `sub_sel` = 0, a subtractive claim drives `devsel_out_n` low first in cycle 4.
- R5: `sub_sel` = 1 moves the subtractive claim to cycle 3. Values 2 and 3 both give cycle 2, which is the earliest allowed.
- R6: If `devsel_in_n` is sampled low in any cycle from 1 up to the one before the subtractive claim cycle, the bridge does not claim. A low seen only from the claim cycle onward does not prevent the claim.
- R7: When `sub_block` is high at the subtractive decision, no subtractive claim is made.
- R8: In boot test mode, memory commands (0110, 0111, 1100, 1110, 1111) to 0xFFF00000–0xFFFFFFFF are claimed from cycle 1 even with `sub_block` high. Addresses outside that range, including ones that differ only in the upper bits, are not positively decoded.
- R9: After `boot_done` is set, the ROM window is handled subtractively, and `sub_block` prevents its claim.
- R10: Only I/O and memory commands are ever claimed. Any other command, such as a configuration read (1010), leaves `devsel_out_n` high.
- R11: In every cycle `par_out` equals the XOR of the AD and C/BE# values of the previous cycle, which gives even parity.
- R12: `par_en` is high in the cycle after a claimed read data phase completes (read means C/BE#[0] = 0 in the address phase). It stays low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | Initiator ready from the bus |
| trdy_n | input | 1 | Target ready from the bus |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command / byte enables |
| devsel_in_n | input | 1 | DEVSEL# driven by other targets |
| sub_block | input | 1 | High blocks subtractive claiming |
| rom_test_n | input | 1 | Low selects the boot ROM test mode |
| boot_done | input | 1 | High once boot has finished |
| sub_sel | input | 2 | Subtractive sample point select |
| devsel_out_n | output | 1 | DEVSEL# driven by this bridge |
| par_out | output | 1 | Even parity of previous AD and C/BE# |
| par_en | output | 1 | PAR drive enable after a claimed read data phase |

## Verification
The assertions assume a well-formed bus. FRAME# falls only from idle. The last data phase ends with FRAME# high while IRDY# stays low until TRDY# completes it. No target answers in the address phase. The directed stimulus keeps to this: each transaction is one address phase followed by a single data phase that completes in cycle 6, then at least two idle clocks. Other targets drive `devsel_in_n` only between cycle 1 and the end of the data phase. `sub_sel`, `sub_block` and the boot inputs are changed only while the bus is idle.

// File: rtl/pci_claim_pkg.sv
package pci_claim_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_CLAIM,
      ST_PASS
   } claim_st_e;

   function automatic logic cmd_is_io(input logic [3:0] c);
      return c[3:1] == 3'b001;
   endfunction

   function automatic logic cmd_is_mem(input logic [3:0] c);
      return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
             (c == 4'b1110) || (c == 4'b1111);
   endfunction

   function automatic logic cmd_is_read(input logic [3:0] c);
      return !c[0];
   endfunction

endpackage

// File: rtl/pci_claim_posdec.sv
module pci_claim_posdec
   import pci_claim_pkg::*;
#(
   parameter int AW       = 32,
   parameter logic [AW-1:0] ROM_BASE = 32'hFFF0_0000,
   parameter int ROM_LOG2 = 20,
   parameter int NUM_IO   = 2,
   parameter logic [(NUM_IO > 0 ? NUM_IO : 1)*AW-1:0] IO_BASES = {32'h0000_0220, 32'h0000_0300},
   parameter int IO_LOG2  = 4
) (
   input  logic [AW-1:0] addr,
   input  logic [3:0]    cmd,
   input  logic          rom_test,
   output logic          hit
);
   localparam int ROM_TAG = AW - ROM_LOG2;
   localparam int IO_TAG  = AW - IO_LOG2;
   localparam int IO_N    = (NUM_IO > 0) ? NUM_IO : 1;

   if (ROM_LOG2 < 1 || ROM_LOG2 >= AW) begin : g_bad_rom
      $error("pci_claim_posdec: ROM_LOG2 out of range");
   end
   if (IO_LOG2 < 1 || IO_LOG2 >= AW) begin : g_bad_io
      $error("pci_claim_posdec: IO_LOG2 out of range");
   end

   logic          rom_hit;
   logic          io_any;
   logic [IO_N-1:0] io_hit;
   logic          unused_addr;

   assign unused_addr = ^addr;
   assign rom_hit = addr[AW-1 -: ROM_TAG] == ROM_BASE[AW-1 -: ROM_TAG];

   if (NUM_IO == 0) begin : g_no_io
      assign io_hit = '0;
      assign io_any = 1'b0;
   end else begin : g_io
      for (genvar i = 0; i < NUM_IO; i++) begin : g_win
         assign io_hit[i] = addr[AW-1 -: IO_TAG] == IO_BASES[i*AW + IO_LOG2 +: IO_TAG];
      end
      assign io_any = |io_hit;
   end

   assign hit = (cmd_is_io(cmd) && io_any) ||
                (rom_test && cmd_is_mem(cmd) && rom_hit);

endmodule

// File: rtl/pci_claim_subwin.sv
module pci_claim_subwin #(
   parameter int SUB_DEFAULT = 4,
   parameter int SUB_MIN     = 2,
   parameter int CFG_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic [CFG_W-1:0] cfg,
   input  logic             ext_devsel_n,
   output logic             decide,
   output logic             others
);
   localparam int CNT_W = $clog2(SUB_DEFAULT + 1);

   if (SUB_MIN < 2) begin : g_bad_min
      $error("pci_claim_subwin: SUB_MIN must be at least 2");
   end
   if (SUB_DEFAULT < SUB_MIN) begin : g_bad_def
      $error("pci_claim_subwin: SUB_DEFAULT below SUB_MIN");
   end

   function automatic logic [CNT_W-1:0] last_cycle(input logic [CFG_W-1:0] c);
      int s;
      s = SUB_DEFAULT - int'(c);
      if (s < SUB_MIN) s = SUB_MIN;
      return CNT_W'(s - 1);
   endfunction

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= '0;
         seen_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= CNT_W'(1);
         last_q <= last_cycle(cfg);
         seen_q <= 1'b0;
      end else if (active) begin
         if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
         if (!ext_devsel_n) seen_q <= 1'b1;
      end
   end

   assign decide = active && (cnt_q == last_q);
   assign others = seen_q || !ext_devsel_n;

   // R5: the decision never falls outside the allowed sample range
   assert_sample_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      decide |-> (cnt_q >= CNT_W'(SUB_MIN - 1)) && (cnt_q <= CNT_W'(SUB_DEFAULT - 1)));

endmodule

// File: rtl/pci_claim_parity.sv
module pci_claim_parity #(
   parameter int AW  = 32,
   parameter int BEW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  ad,
   input  logic [BEW-1:0] cbe_n,
   input  logic           en_next,
   output logic           par,
   output logic           par_en
);
   if (AW < 1 || BEW < 1) begin : g_bad_w
      $error("pci_claim_parity: widths must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par    <= 1'b0;
         par_en <= 1'b0;
      end else begin
         par    <= ^{ad, cbe_n};
         par_en <= en_next;
      end
   end

endmodule

// File: rtl/pci_target_claim.sv
module pci_target_claim
   import pci_claim_pkg::*;
#(
   parameter int AW          = 32,
   parameter logic [AW-1:0] ROM_BASE = 32'hFFF0_0000,
   parameter int ROM_LOG2    = 20,
   parameter int NUM_IO      = 2,
   parameter logic [(NUM_IO > 0 ? NUM_IO : 1)*AW-1:0] IO_BASES = {32'h0000_0220, 32'h0000_0300},
   parameter int IO_LOG2     = 4,
   parameter int SUB_DEFAULT = 4,
   parameter int SUB_MIN     = 2,
   parameter int CFG_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             trdy_n,
   input  logic [AW-1:0]    ad,
   input  logic [3:0]       cbe_n,
   input  logic             devsel_in_n,
   input  logic             sub_block,
   input  logic             rom_test_n,
   input  logic             boot_done,
   input  logic [CFG_W-1:0] sub_sel,
   output logic             devsel_out_n,
   output logic             par_out,
   output logic             par_en
);
   claim_st_e state_q;
   logic      devsel_q;
   logic      read_q;
   logic      pos_hit;
   logic      decide;
   logic      others;
   logic      addr_edge;
   logic      cmd_ok;
   logic      last_done;
   logic      bus_idle;
   logic      par_next;

   assign addr_edge = (state_q == ST_IDLE) && !frame_n;
   assign cmd_ok    = cmd_is_io(cbe_n) || cmd_is_mem(cbe_n);
   assign last_done = frame_n && !irdy_n && !trdy_n;
   assign bus_idle  = frame_n && irdy_n;

   pci_claim_posdec #(
      .AW(AW), .ROM_BASE(ROM_BASE), .ROM_LOG2(ROM_LOG2),
      .NUM_IO(NUM_IO), .IO_BASES(IO_BASES), .IO_LOG2(IO_LOG2)
   ) u_posdec (
      .addr     (ad),
      .cmd      (cbe_n),
      .rom_test (!rom_test_n && !boot_done),
      .hit      (pos_hit)
   );

   pci_claim_subwin #(
      .SUB_DEFAULT(SUB_DEFAULT), .SUB_MIN(SUB_MIN), .CFG_W(CFG_W)
   ) u_subwin (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (addr_edge),
      .active       (state_q == ST_WAIT),
      .cfg          (sub_sel),
      .ext_devsel_n (devsel_in_n),
      .decide       (decide),
      .others       (others)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         devsel_q <= 1'b1;
         read_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (addr_edge) begin
               read_q <= cmd_is_read(cbe_n);
               if (pos_hit) begin
                  state_q  <= ST_CLAIM;
                  devsel_q <= 1'b0;
               end else if (cmd_ok) begin
                  state_q <= ST_WAIT;
               end else begin
                  state_q <= ST_PASS;
               end
            end
            ST_WAIT: if (decide) begin
               if (!others && !sub_block) begin
                  state_q  <= ST_CLAIM;
                  devsel_q <= 1'b0;
               end else begin
                  state_q <= ST_PASS;
               end
            end else if (bus_idle) begin
               state_q <= ST_IDLE;
            end
            ST_CLAIM: if (last_done) begin
               state_q  <= ST_IDLE;
               devsel_q <= 1'b1;
            end
            ST_PASS: if (bus_idle) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign devsel_out_n = devsel_q;
   assign par_next = (state_q == ST_CLAIM) && read_q && !irdy_n && !trdy_n;

   pci_claim_parity #(.AW(AW), .BEW(4)) u_parity (
      .clk     (clk),
      .rst_n   (rst_n),
      .ad      (ad),
      .cbe_n   (cbe_n),
      .en_next (par_next),
      .par     (par_out),
      .par_en  (par_en)
   );

   // R2: a positive decode claims in the very next cycle
   assert_fast_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_edge && pos_hit) |=> !devsel_out_n);

   // R3: completion of the last data phase releases DEVSEL#
   assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel_out_n && last_done) |=> devsel_out_n);

   // R6: another target seen at the decision blocks the claim
   assert_defer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && others) |=> devsel_out_n);

   // R7: the inhibit input at the decision blocks the claim
   assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && sub_block) |=> devsel_out_n);

   // R10: commands outside I/O and memory are never claimed
   assert_cmd_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_edge && !cmd_ok) |=> devsel_out_n);

   // R12: parity drive only follows a cycle in which the bridge held DEVSEL#
   assert_par_claimed_R12: assert property (@(posedge clk) disable iff (!rst_n)
      par_en |-> $past(!devsel_out_n));

endmodule

// File: tb/tb_pci_target_claim.sv
module tb_pci_target_claim;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_n, irdy_n, trdy_n;
   logic [31:0] ad;
   logic [3:0]  cbe_n;
   logic        devsel_in_n, sub_block, rom_test_n, boot_done;
   logic [1:0]  sub_sel;
   logic        devsel_out_n, par_out, par_en;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   pci_target_claim dut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
      .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .devsel_in_n(devsel_in_n),
      .sub_block(sub_block), .rom_test_n(rom_test_n), .boot_done(boot_done),
      .sub_sel(sub_sel), .devsel_out_n(devsel_out_n), .par_out(par_out),
      .par_en(par_en)
   );

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_bus();
      frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; devsel_in_n = 1'b1;
      ad = 32'h0; cbe_n = 4'hF;
   endtask

   // One address phase, one data phase completing in cycle 6.
   // exp_cyc: first cycle with devsel_out_n low (0 = never); ext_cyc: first cycle another target answers.
   task automatic txn(input string req, input logic [31:0] addr, input logic [3:0] cmd,
                      input int exp_cyc, input int ext_cyc);
      logic [31:0] data;
      data = addr ^ 32'h5A3C_0F96;
      @(negedge clk);
      frame_n = 1'b0; ad = addr; cbe_n = cmd;
      for (int c = 1; c <= 7; c++) begin
         @(negedge clk);
         if (c == 1)
            chk(par_out == ^{addr, cmd}, "R11", "address parity", 32'(par_out), 32'(^{addr, cmd}));
         if (c <= 6) begin
            logic e;
            e = !(exp_cyc != 0 && c >= exp_cyc);
            chk(devsel_out_n == e, req, $sformatf("devsel cycle %0d", c), 32'(devsel_out_n), 32'(e));
         end else begin
            logic pe;
            pe = (exp_cyc != 0) && !cmd[0];
            chk(devsel_out_n == 1'b1, "R3", "release after last phase", 32'(devsel_out_n), 32'd1);
            chk(par_en == pe, "R12", "parity enable", 32'(par_en), 32'(pe));
            chk(par_out == ^{data, 4'h0}, "R11", "data parity", 32'(par_out), 32'(^{data, 4'h0}));
         end
         if (c == 1) begin
            frame_n = 1'b1; irdy_n = 1'b0; ad = data; cbe_n = 4'h0;
         end
         devsel_in_n = !(ext_cyc != 0 && c >= ext_cyc && c <= 6);
         trdy_n = !(c == 6 && (exp_cyc != 0 || ext_cyc != 0));
         if (c == 7) idle_bus();
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; idle_bus();
      sub_block = 1'b0; rom_test_n = 1'b1; boot_done = 1'b0; sub_sel = 2'd0;
      repeat (3) @(negedge clk);
      chk(devsel_out_n == 1'b1, "R1", "devsel in reset", 32'(devsel_out_n), 32'd1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(devsel_out_n == 1'b1, "R1", "devsel after reset", 32'(devsel_out_n), 32'd1);
      chk(par_en == 1'b0, "R1", "par_en after reset", 32'(par_en), 32'd0);
   endtask

   task automatic t_positive_io();
      txn("R2", 32'h0000_0304, 4'b0010, 1, 0);   // read in window 0x300
      txn("R2", 32'h0000_022C, 4'b0011, 1, 0);   // write in window 0x220
      txn("R2", 32'h0000_0304, 4'b0110, 4, 0);   // memory command: subtractive only
      txn("R2", 32'h1000_0304, 4'b0010, 4, 0);   // upper bits differ: no window hit
   endtask

   task automatic t_sub_points();
      sub_sel = 2'd0; txn("R4", 32'h000C_8000, 4'b0110, 4, 0);
      sub_sel = 2'd1; txn("R5", 32'h000C_8000, 4'b0110, 3, 0);
      sub_sel = 2'd2; txn("R5", 32'h000C_8000, 4'b0110, 2, 0);
      sub_sel = 2'd3; txn("R5", 32'h000C_8000, 4'b0111, 2, 0);
      sub_sel = 2'd0;
   endtask

   task automatic t_other_target();
      txn("R6", 32'h000D_0000, 4'b0110, 0, 3);   // last cycle of the window
      txn("R6", 32'h000D_0000, 4'b0110, 0, 1);
      txn("R6", 32'h000D_0000, 4'b0110, 4, 4);   // too late to prevent the claim
      sub_sel = 2'd1;
      txn("R6", 32'h000D_0000, 4'b0110, 0, 2);
      sub_sel = 2'd0;
   endtask

   task automatic t_inhibit();
      sub_block = 1'b1;
      txn("R7", 32'h000C_8000, 4'b0110, 0, 0);
      txn("R7", 32'h0000_0060, 4'b0010, 0, 0);
      txn("R7", 32'h0000_0300, 4'b0010, 1, 0);   // positive I/O window still claimed
      sub_block = 1'b0;
   endtask

   task automatic t_rom_test();
      rom_test_n = 1'b0; boot_done = 1'b0; sub_block = 1'b1;
      txn("R8", 32'hFFFF_0000, 4'b0110, 1, 0);
      txn("R8", 32'hFFF0_0000, 4'b1100, 1, 0);
      txn("R8", 32'hFFEF_FFFC, 4'b0110, 0, 0);
      txn("R8", 32'h0FFF_0000, 4'b0110, 0, 0);
      txn("R8", 32'hFFFF_0000, 4'b0010, 0, 0);   // I/O command: not a ROM hit
      sub_block = 1'b0;
   endtask

   task automatic t_after_boot();
      boot_done = 1'b1; sub_block = 1'b1;
      txn("R9", 32'hFFFF_0000, 4'b0110, 0, 0);
      sub_block = 1'b0;
      txn("R9", 32'hFFFF_0000, 4'b0110, 4, 0);
      rom_test_n = 1'b1; boot_done = 1'b0;
   endtask

   task automatic t_commands();
      txn("R10", 32'h000C_8000, 4'b1010, 0, 0);  // configuration read
      txn("R10", 32'h000C_8000, 4'b0000, 0, 0);  // interrupt acknowledge
      txn("R10", 32'h0000_0060, 4'b0010, 4, 0);  // unmapped I/O: subtractive
   endtask

   initial begin
      t_reset();
      t_positive_io();
      t_sub_points();
      t_other_target();
      t_inhibit();
      t_rom_test();
      t_after_boot();
      t_commands();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #200000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule